// File: doc/BRIEF.md
# Streaming Line Read Buffer

This block sits between a 16-byte load port and a non-cacheable memory port. For streaming loads to write-combining memory, it fetches the whole 64-byte line in one memory transaction and parks it in one of a small pool of line buffers. Later streaming loads to other chunks of that line are answered from the buffer without touching memory. Each buffer tracks which of its four chunks have already been handed out. A buffer is released as soon as all four chunks have been delivered. Asking again for a chunk that was already delivered forces a fresh line fetch.

All other loads go straight to memory as single 16-byte reads. These are plain loads, and streaming loads to memory that is not write-combining. Such loads never occupy a buffer. Stores reach the block only as notifications, so that it can drop a buffered line that has gone stale. A plain load to a buffered line also drops that line. Only one memory request is in flight at a time. While a fill or pass-through read is pending, the load port is held off.

Top module: `stream_line_buf`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and memReqValid is 0.
- R2: A load (reqKind other than 2) whose address has a non-zero value in bits [3:0] is answered in the cycle after acceptance. The response has rspValid=1 and rspErr=1, and no memory request is made for it.
- R3: A streaming load (reqKind=1) to write-combining memory (reqWc=1) that finds no buffered copy of its line issues one memory request with memReqLine=1 and a 64-byte-aligned address. Memory returns chunk k of the line in memRspData bits [128k+127:128k]. The block answers the cycle after memRspValid with the requested chunk and rspErr=0.
- R4: A streaming load to write-combining memory whose chunk is in a buffer and not yet delivered is answered in the cycle after acceptance, with no memory request. Chunks may be requested in any order.
- R5: Requesting a chunk that was already delivered from a held line causes a new 64-byte fetch of that line. Undelivered chunks of the refreshed line are then served from the buffer.
- R6: Once all four chunks of a line have been delivered, its buffer is released. The next streaming load to that line fetches it again.
- R7: With all four buffers occupied, a streaming miss replaces the buffer whose line was least recently filled or served.
- R8: A free buffer is always chosen for a new line before any occupied buffer is replaced.
- R9: A plain load (reqKind 0 or 3), or a streaming load with reqWc=0, makes one memory request with memReqLine=0 and its 16-byte-aligned address. Memory returns the chunk in memRspData bits [127:0], and the block answers with that chunk. No buffer is allocated.
- R10: A store notification (reqKind=2), or a plain load, to a line held in a buffer invalidates that buffer. A store notification produces no response and no memory request.
- R11: From acceptance of a load that needs memory until its response, reqReady is 0. A memory request holds its address and size stable until memReqReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqKind | input | 2 | 0/3 plain load, 1 streaming load, 2 store notification |
| reqWc | input | 1 | Target memory is write-combining |
| rspValid | output | 1 | Response strobe, one cycle |
| rspData | output | CHUNK_W | Returned 16-byte chunk |
| rspErr | output | 1 | Misaligned request error |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Aligned memory address |
| memReqLine | output | 1 | 1 = 64-byte line, 0 = 16-byte chunk |
| memRspValid | input | 1 | Memory data strobe |
| memRspData | input | CHUNK_W*CHUNKS | Memory data |

## Verification
The assertions check the handshake properties on every cycle. These are the error response and missing memory traffic for misaligned loads, silence after a store notification, the load port being held off while a memory request is pending, and the stability of a waiting memory request. Whether a load is served from a buffer or goes to memory depends on buffer history. That history includes the order chunks were consumed, re-reads, release after the fourth chunk, invalidation and age-based replacement. Only the directed scenarios can show it, by counting line and chunk fetches at the memory model and comparing returned data.

// File: rtl/stream_line_buf_pkg.sv
package stream_line_buf_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD     = 2'd0,
    KIND_STREAM   = 2'd1,
    KIND_STORE    = 2'd2,
    KIND_LOAD_ALT = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hitRd;   // serve chunk from buffer
    logic fillWr;  // write fetched line into buffer
    logic passWr;  // capture single-chunk read data
    logic errRsp;  // zero the response data
    logic inval;   // drop buffer holding the looked-up line
  } dpStrobe_t;

endpackage

// File: rtl/stream_line_buf_dp.sv
module stream_line_buf_dp
  import stream_line_buf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_BUF = 4,
  parameter int CHUNK_W = 128,
  parameter int CHUNKS  = 4,
  parameter int OFF_W   = $clog2(CHUNK_W / 8),
  parameter int CIDX_W  = $clog2(CHUNKS),
  parameter int SLOT_W  = $clog2(NUM_BUF)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   stb,
  input  logic [ADDR_W-OFF_W-1:0]     lkIdx,
  input  logic [ADDR_W-OFF_W-1:0]     fillIdx,
  input  logic [SLOT_W-1:0]           fillSlot,
  input  logic [CHUNK_W*CHUNKS-1:0]   memRspData,
  output logic                        lineHit,
  output logic                        chunkFresh,
  output logic [SLOT_W-1:0]           hitSlot,
  output logic [SLOT_W-1:0]           victimSlot,
  output logic [CHUNK_W-1:0]          rspData
);

  localparam int LINE_W = CHUNK_W * CHUNKS;
  localparam int TAG_W  = ADDR_W - OFF_W - CIDX_W;

  logic              slotValid [NUM_BUF];
  logic [TAG_W-1:0]  slotTag   [NUM_BUF];
  logic [CHUNKS-1:0] slotUsed  [NUM_BUF];
  logic [SLOT_W-1:0] slotAge   [NUM_BUF];
  logic [LINE_W-1:0] slotData  [NUM_BUF];

  logic [TAG_W-1:0]  lkTag, fillTag;
  logic [CIDX_W-1:0] lkChunk, fillChunk;
  logic [NUM_BUF-1:0] matchVec;
  logic [CHUNKS-1:0] hitUsed;
  logic              touchEn;
  logic [SLOT_W-1:0] touchSlot;
  logic              freeFound;

  assign lkTag     = lkIdx[ADDR_W-OFF_W-1:CIDX_W];
  assign lkChunk   = lkIdx[CIDX_W-1:0];
  assign fillTag   = fillIdx[ADDR_W-OFF_W-1:CIDX_W];
  assign fillChunk = fillIdx[CIDX_W-1:0];

  // per-slot tag comparators
  for (genvar g = 0; g < NUM_BUF; g++) begin : gMatch
    assign matchVec[g] = slotValid[g] && (slotTag[g] == lkTag);
  end

  always_comb begin
    lineHit = 1'b0;
    hitSlot = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (matchVec[i]) begin
        lineHit = 1'b1;
        hitSlot = SLOT_W'(i);
      end
    end
  end

  assign chunkFresh = !slotUsed[hitSlot][lkChunk];
  assign hitUsed    = slotUsed[hitSlot] | (CHUNKS'(1) << lkChunk);

  // free slot first, otherwise the oldest one
  always_comb begin
    freeFound  = 1'b0;
    victimSlot = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (!freeFound && !slotValid[i]) begin
        freeFound  = 1'b1;
        victimSlot = SLOT_W'(i);
      end
    end
    if (!freeFound) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (slotAge[i] == SLOT_W'(NUM_BUF - 1)) victimSlot = SLOT_W'(i);
      end
    end
  end

  assign touchEn   = stb.hitRd | stb.fillWr;
  assign touchSlot = stb.hitRd ? hitSlot : fillSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        slotValid[i] <= 1'b0;
        slotTag[i]   <= '0;
        slotUsed[i]  <= '0;
        slotAge[i]   <= SLOT_W'(i);
      end
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (touchEn) begin
          if (SLOT_W'(i) == touchSlot) slotAge[i] <= '0;
          else if (slotAge[i] < slotAge[touchSlot]) slotAge[i] <= slotAge[i] + 1'b1;
        end
        if (stb.hitRd && hitSlot == SLOT_W'(i)) begin
          slotUsed[i] <= hitUsed;
          if (&hitUsed) slotValid[i] <= 1'b0;
        end
        if (stb.fillWr && fillSlot == SLOT_W'(i)) begin
          slotValid[i] <= 1'b1;
          slotTag[i]   <= fillTag;
          slotUsed[i]  <= CHUNKS'(1) << fillChunk;
        end
        if (stb.inval && lineHit && hitSlot == SLOT_W'(i)) slotValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fillWr) slotData[fillSlot] <= memRspData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspData <= '0;
    else if (stb.errRsp) rspData <= '0;
    else if (stb.hitRd) rspData <= slotData[hitSlot][lkChunk*CHUNK_W +: CHUNK_W];
    else if (stb.fillWr) rspData <= memRspData[fillChunk*CHUNK_W +: CHUNK_W];
    else if (stb.passWr) rspData <= memRspData[CHUNK_W-1:0];
  end

endmodule

// File: rtl/stream_line_buf_ctrl.sv
module stream_line_buf_ctrl
  import stream_line_buf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int CIDX_W = 2,
  parameter int SLOT_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqKind,
  input  logic                    reqWc,
  input  logic                    lineHit,
  input  logic                    chunkFresh,
  input  logic [SLOT_W-1:0]       hitSlot,
  input  logic [SLOT_W-1:0]       victimSlot,
  output dpStrobe_t               stb,
  output logic [ADDR_W-OFF_W-1:0] pendIdx,
  output logic [SLOT_W-1:0]       fillSlot,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic                    memReqLine,
  input  logic                    memRspValid,
  output logic                    rspValid,
  output logic                    rspErr
);

  localparam int LINE_LSB = OFF_W + CIDX_W;

  ctrlState_e state;
  logic reqFire, isStore, misal, wcStream;
  logic errCase, storeCase, hitCase, fillCase, passCase;

  assign reqReady = (state == ST_IDLE);
  assign reqFire  = reqValid && reqReady;
  assign isStore  = (reqKind == KIND_STORE);
  assign misal    = |reqAddr[OFF_W-1:0];
  assign wcStream = (reqKind == KIND_STREAM) && reqWc;

  assign errCase   = reqFire && !isStore && misal;
  assign storeCase = reqFire && isStore;
  assign hitCase   = reqFire && !isStore && !misal && wcStream && lineHit && chunkFresh;
  assign fillCase  = reqFire && !isStore && !misal && wcStream && !(lineHit && chunkFresh);
  assign passCase  = reqFire && !isStore && !misal && !wcStream;

  always_comb begin
    stb        = '0;
    stb.errRsp = errCase;
    stb.hitRd  = hitCase;
    stb.inval  = storeCase | passCase;
    stb.fillWr = (state == ST_WAIT) && memRspValid && memReqLine;
    stb.passWr = (state == ST_WAIT) && memRspValid && !memReqLine;
  end

  assign memReqValid = (state == ST_ISSUE);
  assign memReqAddr  = memReqLine
                     ? {pendIdx[ADDR_W-OFF_W-1:CIDX_W], LINE_LSB'(0)}
                     : {pendIdx, OFF_W'(0)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pendIdx    <= '0;
      memReqLine <= 1'b0;
      fillSlot   <= '0;
      rspValid   <= 1'b0;
      rspErr     <= 1'b0;
    end else begin
      rspValid <= errCase | hitCase | stb.fillWr | stb.passWr;
      rspErr   <= errCase;
      case (state)
        ST_IDLE: begin
          if (fillCase) begin
            pendIdx    <= reqAddr[ADDR_W-1:OFF_W];
            memReqLine <= 1'b1;
            fillSlot   <= lineHit ? hitSlot : victimSlot;
            state      <= ST_ISSUE;
          end else if (passCase) begin
            pendIdx    <= reqAddr[ADDR_W-1:OFF_W];
            memReqLine <= 1'b0;
            state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (memReqReady) state <= ST_WAIT;
        ST_WAIT:  if (memRspValid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stream_line_buf.sv
module stream_line_buf
  import stream_line_buf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_BUF = 4,
  parameter int CHUNK_W = 128,
  parameter int CHUNKS  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqKind,
  input  logic                      reqWc,
  output logic                      rspValid,
  output logic [CHUNK_W-1:0]        rspData,
  output logic                      rspErr,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic                      memReqLine,
  input  logic                      memRspValid,
  input  logic [CHUNK_W*CHUNKS-1:0] memRspData
);

  localparam int OFF_W    = $clog2(CHUNK_W / 8);
  localparam int CIDX_W   = $clog2(CHUNKS);
  localparam int LINE_LSB = OFF_W + CIDX_W;
  localparam int SLOT_W   = $clog2(NUM_BUF);

  dpStrobe_t               stb;
  logic                    lineHit, chunkFresh;
  logic [SLOT_W-1:0]       hitSlot, victimSlot, fillSlot;
  logic [ADDR_W-OFF_W-1:0] pendIdx;

  stream_line_buf_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CIDX_W(CIDX_W), .SLOT_W(SLOT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqWc(reqWc),
    .lineHit(lineHit), .chunkFresh(chunkFresh),
    .hitSlot(hitSlot), .victimSlot(victimSlot),
    .stb(stb), .pendIdx(pendIdx), .fillSlot(fillSlot),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqLine(memReqLine),
    .memRspValid(memRspValid),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  stream_line_buf_dp #(
    .ADDR_W(ADDR_W), .NUM_BUF(NUM_BUF), .CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS),
    .OFF_W(OFF_W), .CIDX_W(CIDX_W), .SLOT_W(SLOT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .lkIdx(reqAddr[ADDR_W-1:OFF_W]), .fillIdx(pendIdx), .fillSlot(fillSlot),
    .memRspData(memRspData),
    .lineHit(lineHit), .chunkFresh(chunkFresh),
    .hitSlot(hitSlot), .victimSlot(victimSlot),
    .rspData(rspData)
  );

endmodule

// File: rtl/stream_line_buf_chk.sv
module stream_line_buf_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 4,
  parameter int LINE_LSB = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [OFF_W-1:0]  reqOff,
  input logic [1:0]        reqKind,
  input logic              rspValid,
  input logic              rspErr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memReqLine
);

  // R2
  misal_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind != 2'd2 && |reqOff) |=> (rspValid && rspErr && !memReqValid));

  // R2
  err_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  // R10
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind == 2'd2) |=> (!rspValid && !memReqValid));

  // R11
  one_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr) && $stable(memReqLine)));

  // R3
  line_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqLine) |-> (memReqAddr[LINE_LSB-1:0] == '0));

  // R9
  chunk_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[OFF_W-1:0] == '0));

endmodule

bind stream_line_buf stream_line_buf_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_LSB(LINE_LSB)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqOff(reqAddr[OFF_W-1:0]), .reqKind(reqKind),
  .rspValid(rspValid), .rspErr(rspErr),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memReqLine(memReqLine)
);

// File: tb/tb_stream_line_buf.sv
module tb_stream_line_buf;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic         reqReady;
  logic [31:0]  reqAddr;
  logic [1:0]   reqKind;
  logic         reqWc;
  logic         rspValid;
  logic [127:0] rspData;
  logic         rspErr;
  logic         memReqValid;
  logic         memReqReady;
  logic [31:0]  memReqAddr;
  logic         memReqLine;
  logic         memRspValid;
  logic [511:0] memRspData;

  int checks = 0;
  int errors = 0;
  int lineFetches = 0;
  int chunkFetches = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stream_line_buf dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqWc(reqWc),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqLine(memReqLine),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  function automatic logic [127:0] chunkVal(input logic [31:0] a);
    return {a, ~a, a ^ 32'h5A5A_5A5A, a + 32'h0001_2345};
  endfunction

  function automatic logic [511:0] lineVal(input logic [31:0] la);
    return {chunkVal(la + 32'd48), chunkVal(la + 32'd32), chunkVal(la + 32'd16), chunkVal(la)};
  endfunction

  // memory model: fixed latency, always ready
  initial begin
    logic        busy;
    int          cnt;
    logic [31:0] capAddr;
    logic        capLine;
    busy = 1'b0; cnt = 0; capAddr = '0; capLine = 1'b0;
    memReqReady = 1'b1;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (busy) begin
        cnt--;
        if (cnt == 0) begin
          busy = 1'b0;
          memRspValid = 1'b1;
          memRspData  = capLine ? lineVal(capAddr) : {384'b0, chunkVal(capAddr)};
        end
      end else if (memReqValid && rstN) begin
        busy = 1'b1; cnt = 2;
        capAddr = memReqAddr; capLine = memReqLine;
        if (capLine) lineFetches++;
        else chunkFetches++;
      end
    end
  end

  task automatic checkEq(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic [1:0] kind, input logic wc, input logic [31:0] addr,
                       output logic [127:0] data, output logic err, output int lat,
                       output int lf, output int cf);
    int l0, c0;
    @(negedge clk);
    l0 = lineFetches; c0 = chunkFetches;
    reqValid = 1'b1; reqKind = kind; reqWc = wc; reqAddr = addr;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    if (kind != 2'd2) begin
      while (!rspValid && lat < 60) begin
        @(negedge clk);
        lat++;
      end
    end
    data = rspData; err = rspErr;
    lf = lineFetches - l0; cf = chunkFetches - c0;
  endtask

  // streaming load to write-combining memory
  task automatic sl(input logic [31:0] addr, input int expLf, input string req);
    logic [127:0] d; logic e; int lat, lf, cf;
    doReq(2'd1, 1'b1, addr, d, e, lat, lf, cf);
    checkEq(req, $sformatf("data @%h", addr), d, chunkVal(addr));
    checkEq(req, $sformatf("line fetches @%h", addr), 128'(lf), 128'(expLf));
    if (expLf == 0) checkEq(req, $sformatf("hit latency @%h", addr), 128'(lat), 128'd1);
  endtask

  task automatic testReset();
    checkEq("R1", "reqReady", 128'(reqReady), 128'd1);
    checkEq("R1", "rspValid", 128'(rspValid), 128'd0);
    checkEq("R1", "memReqValid", 128'(memReqValid), 128'd0);
  endtask

  task automatic testAscending();
    sl(32'h0000_1000, 1, "R3");
    sl(32'h0000_1010, 0, "R4");
    sl(32'h0000_1020, 0, "R4");
    sl(32'h0000_1030, 0, "R4");
    sl(32'h0000_1000, 1, "R6");
  endtask

  task automatic testAnyOrder();
    sl(32'h0000_2060, 1, "R3");
    sl(32'h0000_2040, 0, "R4");
    sl(32'h0000_2070, 0, "R4");
    sl(32'h0000_2050, 0, "R4");
  endtask

  task automatic testReread();
    sl(32'h0000_3080, 1, "R3");
    sl(32'h0000_3080, 1, "R5");
    sl(32'h0000_3090, 0, "R5");
  endtask

  task automatic testPassThrough();
    logic [127:0] d; logic e; int lat, lf, cf;
    doReq(2'd1, 1'b0, 32'h0000_40C0, d, e, lat, lf, cf);
    checkEq("R9", "non-wc stream data", d, chunkVal(32'h0000_40C0));
    checkEq("R9", "non-wc chunk fetch", 128'(cf), 128'd1);
    checkEq("R9", "non-wc line fetch", 128'(lf), 128'd0);
    doReq(2'd0, 1'b1, 32'h0000_40D0, d, e, lat, lf, cf);
    checkEq("R9", "plain load data", d, chunkVal(32'h0000_40D0));
    checkEq("R9", "plain load chunk fetch", 128'(cf), 128'd1);
    doReq(2'd3, 1'b0, 32'h0000_40E0, d, e, lat, lf, cf);
    checkEq("R9", "alt load data", d, chunkVal(32'h0000_40E0));
    // no allocation from the above: streaming load must fetch the line
    sl(32'h0000_40F0, 1, "R9");
  endtask

  task automatic testInvalidate();
    logic [127:0] d; logic e; int lat, lf, cf;
    sl(32'h0000_5000, 1, "R3");
    doReq(2'd2, 1'b1, 32'h0000_5020, d, e, lat, lf, cf);
    checkEq("R10", "store no response", 128'(rspValid), 128'd0);
    checkEq("R10", "store no fetch", 128'(lf + cf), 128'd0);
    sl(32'h0000_5010, 1, "R10");
    sl(32'h0000_6000, 1, "R3");
    doReq(2'd0, 1'b1, 32'h0000_6030, d, e, lat, lf, cf);
    checkEq("R10", "plain load data", d, chunkVal(32'h0000_6030));
    sl(32'h0000_6010, 1, "R10");
  endtask

  task automatic testMisaligned();
    logic [127:0] d; logic e; int lat, lf, cf;
    doReq(2'd1, 1'b1, 32'h0000_7008, d, e, lat, lf, cf);
    checkEq("R2", "error flag", 128'(e), 128'd1);
    checkEq("R2", "error latency", 128'(lat), 128'd1);
    checkEq("R2", "no memory traffic", 128'(lf + cf), 128'd0);
    doReq(2'd0, 1'b0, 32'h0000_7024, d, e, lat, lf, cf);
    checkEq("R2", "plain load error flag", 128'(e), 128'd1);
    checkEq("R2", "plain load no memory traffic", 128'(lf + cf), 128'd0);
  endtask

  task automatic testLru();
    for (int k = 0; k < 4; k++) sl(32'h0000_8000 + 32'(k) * 32'h40, 1, "R7");
    sl(32'h0000_8010, 0, "R7");          // touch line 0; line 1 now oldest
    sl(32'h0000_8100, 1, "R7");          // new line evicts line 1
    sl(32'h0000_8020, 0, "R7");
    sl(32'h0000_8090, 0, "R7");
    sl(32'h0000_80D0, 0, "R7");
    sl(32'h0000_8050, 1, "R7");          // evicted line misses
  endtask

  task automatic testFreeFirst();
    for (int k = 0; k < 4; k++) sl(32'h0000_9000 + 32'(k) * 32'h40, 1, "R8");
    sl(32'h0000_9010, 0, "R6");
    sl(32'h0000_9020, 0, "R6");
    sl(32'h0000_9030, 0, "R6");          // line 0 fully delivered, slot freed
    sl(32'h0000_9100, 1, "R8");          // takes the free slot
    sl(32'h0000_9050, 0, "R8");          // oldest occupied line still held
    sl(32'h0000_9090, 0, "R8");
    sl(32'h0000_90D0, 0, "R8");
  endtask

  task automatic testHoldOff();
    // R11: port held off while a fill is pending
    int lowCycles;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd1; reqWc = 1'b1; reqAddr = 32'h0000_A000;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lowCycles = 0;
    while (!rspValid && lowCycles < 60) begin
      if (!reqReady) lowCycles++;
      @(negedge clk);
    end
    checkEq("R11", "ready low during fill", 128'(lowCycles > 1), 128'd1);
    checkEq("R11", "fill data", rspData, chunkVal(32'h0000_A000));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqKind = 2'd0; reqWc = 1'b0;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAscending();
    testAnyOrder();
    testReread();
    testPassThrough();
    testInvalidate();
    testMisaligned();
    testLru();
    testFreeFirst();
    testHoldOff();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule